// File: doc/BRIEF.md
# Byte-Wide Enable-Strobe Peripheral Bus Master

This block turns single register accesses from on-chip logic into bus cycles on a byte-wide, enable-strobed peripheral bus of the kind that slow display controllers use. A request on a valid/ready port carries a read/write flag, a one-bit register select and a write byte. The block drives an active-low chip select, its active-high companion, the register select, a read/not-write line and the enable strobe E. It drives the data bus through an output value and an output enable, and samples the returning byte from a separate input, so the pad ring builds the tri-state buffer. A read returns its byte with a one-cycle done pulse.

All bus timing comes from phase counters, with the limits converted from nanoseconds to clock ticks. Each limit is rounded up and given one tick of margin. A mode input picks a fast or a slow timing profile. The block samples this input only when it accepts a request, so both profiles share one state machine and a change never reaches a transfer already in progress. E stays high longer on reads than on writes, because a read must also cover the peripheral's access time.

Top module: `ebus_master`

## Requirements
- R1: After reset, cmdReady is 1, busCsN is 1, busCs2 is 0, busE is 0, busDOe is 0 and rspDone is 0.
- R2: A request is accepted on a clock edge where cmdValid and cmdReady are both 1. cmdReady then stays 0 until at least the profile's cycle time (31 ticks fast, 101 slow) has passed since the transfer's E rise.
- R3: From acceptance through the hold phase after E falls, busCsN is 0 and busCs2 is 1. busSel and busRnw stay constant over that span, with busRnw = 1 for a read and 0 for a write. E is never high unless the chip is selected.
- R4: Before E rises, E stays low with the chip selected for at least 7 ticks (fast) or 13 ticks (slow).
- R5: On a write, E is high for 7 ticks (fast) or 13 ticks (slow).
- R6: On a read, E is high for 16 ticks (fast) or 30 ticks (slow). The byte on busDIn is captured at the edge where E is driven low. rspDone is 1 for exactly the first cycle in which E is low again, with the captured byte on rspData.
- R7: On a write, busDOe is 1 with the write byte on busDOut for at least 5 ticks (fast) or 9 ticks (slow) before E falls. It stays 1 for exactly 3 ticks (fast) or 4 ticks (slow) after E falls. busDOe is never 1 during a read.
- R8: After a read's E falls, busDOe stays 0 for 11 ticks (fast) or 21 ticks (slow), the peripheral's release window.
- R9: Successive E rises are at least the profile's cycle time apart (31 ticks fast, 101 slow).
- R10: slowMode is sampled only when a request is accepted (1 = slow profile). Changing it during a transfer does not change that transfer's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 10 ns period assumed by the default parameters |
| rstN | input | 1 | Asynchronous active-low reset |
| slowMode | input | 1 | Profile select, 1 = slow, sampled at acceptance |
| cmdValid | input | 1 | Request present |
| cmdReady | output | 1 | Block can accept a request |
| cmdRead | input | 1 | 1 = read, 0 = write |
| cmdSel | input | 1 | Register select driven onto busSel |
| cmdWData | input | 8 | Write byte |
| rspDone | output | 1 | One-cycle pulse when read data is valid |
| rspData | output | 8 | Captured read byte |
| busCsN | output | 1 | Chip select, active low |
| busCs2 | output | 1 | Second chip select, active high |
| busSel | output | 1 | Register select |
| busRnw | output | 1 | 1 = read, 0 = write |
| busE | output | 1 | Enable strobe |
| busDOut | output | 8 | Data bus output value |
| busDOe | output | 1 | Data bus output enable |
| busDIn | input | 8 | Data bus input value |

## Verification
All bus pins are decoded from registered state, so each pin changes in the cycle after the edge that moves the state machine. rspDone and rspData are registered on the same edge that drops E, so they are due in the first sample where E reads low. The bench samples every output on the falling clock edge, half a tick after the edge that updated it. A peripheral model counts those samples to measure E-low, E-high, rise-to-rise, data-setup and data-hold spans exactly in ticks. It drives read data only once the access delay has passed since E rose, and keeps driving for the release window after E falls, so an early capture or a premature output enable shows up as a wrong byte or a flagged overlap.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

  localparam int TK_W = 8;
  typedef logic [TK_W-1:0] tk_t;

  // profile limits in nanoseconds
  typedef struct packed {
    int cycNs;
    int rdHighNs;
    int wrHighNs;
    int lowNs;
    int setupNs;
    int holdNs;
    int accNs;
    int disNs;
  } busNs_t;

  // profile limits in clock ticks
  typedef struct packed {
    tk_t cyc;
    tk_t rdHigh;
    tk_t wrHigh;
    tk_t low;
    tk_t hold;
    tk_t dis;
  } busTk_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic capture;
    logic csOn;
    logic eOn;
    logic rnw;
    logic oeOn;
  } ctrlStrobe_t;

  function automatic int ceilTicks(int ns, int clkNs);
    return (ns + clkNs - 1) / clkNs + 1;
  endfunction

  function automatic int maxInt(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic busTk_t toTicks(busNs_t t, int clkNs);
    busTk_t r;
    r.cyc    = tk_t'(ceilTicks(t.cycNs, clkNs));
    r.rdHigh = tk_t'(maxInt(ceilTicks(t.rdHighNs, clkNs), ceilTicks(t.accNs, clkNs) + 1));
    r.wrHigh = tk_t'(maxInt(ceilTicks(t.wrHighNs, clkNs), ceilTicks(t.setupNs, clkNs)));
    r.low    = tk_t'(ceilTicks(t.lowNs, clkNs));
    r.hold   = tk_t'(ceilTicks(t.holdNs, clkNs));
    r.dis    = tk_t'(ceilTicks(t.disNs, clkNs));
    return r;
  endfunction

endpackage

// File: rtl/ebus_ctrl.sv
module ebus_ctrl
  import ebus_pkg::*;
#(
  parameter busTk_t FAST_TK = '0,
  parameter busTk_t SLOW_TK = '0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        slowMode,
  input  logic        cmdValid,
  input  logic        cmdRead,
  output logic        cmdReady,
  output ctrlStrobe_t strobe
);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_HIGH, S_HOLD, S_WAIT} state_t;

  state_t state;
  logic   rnwReg;
  logic   slowSel;
  tk_t    phCnt;
  tk_t    cycCnt;
  tk_t    turnCnt;
  busTk_t tk;
  tk_t    highTicks;
  logic   highLast;

  assign tk        = slowSel ? SLOW_TK : FAST_TK;
  assign highTicks = rnwReg ? tk.rdHigh : tk.wrHigh;
  assign highLast  = (state == S_HIGH) && (phCnt == highTicks - tk_t'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      rnwReg  <= 1'b1;
      slowSel <= 1'b0;
      phCnt   <= '0;
      cycCnt  <= '0;
      turnCnt <= '0;
    end else begin
      if (state == S_HIGH || state == S_HOLD || state == S_WAIT) begin
        if (cycCnt != '1) cycCnt <= cycCnt + tk_t'(1);
      end
      if (highLast && rnwReg) turnCnt <= tk.dis;
      else if (turnCnt != '0) turnCnt <= turnCnt - tk_t'(1);

      unique case (state)
        S_IDLE: if (cmdValid) begin
          state   <= S_SETUP;
          rnwReg  <= cmdRead;
          slowSel <= slowMode;
          phCnt   <= '0;
        end
        S_SETUP: begin
          if (phCnt >= tk.low - tk_t'(1) && turnCnt == '0) begin
            state  <= S_HIGH;
            phCnt  <= '0;
            cycCnt <= tk_t'(1);
          end else if (phCnt < tk.low - tk_t'(1)) begin
            phCnt <= phCnt + tk_t'(1);
          end
        end
        S_HIGH: begin
          if (highLast) begin
            state <= S_HOLD;
            phCnt <= '0;
          end else phCnt <= phCnt + tk_t'(1);
        end
        S_HOLD: begin
          if (phCnt == tk.hold - tk_t'(1)) state <= S_WAIT;
          else phCnt <= phCnt + tk_t'(1);
        end
        S_WAIT: if (cycCnt >= tk.cyc) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cmdReady       = (state == S_IDLE);
  assign strobe.load    = (state == S_IDLE) && cmdValid;
  assign strobe.capture = highLast && rnwReg;
  assign strobe.csOn    = (state == S_SETUP) || (state == S_HIGH) || (state == S_HOLD);
  assign strobe.eOn     = (state == S_HIGH);
  assign strobe.rnw     = rnwReg;
  assign strobe.oeOn    = !rnwReg && ((state == S_HIGH) || (state == S_HOLD) ||
                                      ((state == S_SETUP) && turnCnt == '0));

  // R2: acceptance drops ready on the next cycle
  a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdReady |=> !cmdReady);
  // R3: E only while the chip is selected
  a_r3_e_needs_cs: assert property (@(posedge clk) disable iff (!rstN)
    strobe.eOn |-> strobe.csOn);
  // R8: no output drive inside the release window
  a_r8_turnaround: assert property (@(posedge clk) disable iff (!rstN)
    strobe.oeOn |-> turnCnt == '0);
  // R10: profile frozen while a transfer is in progress
  a_r10_profile_held: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE) && $past(state != S_IDLE) |-> $stable(slowSel));

endmodule

// File: rtl/ebus_datapath.sv
module ebus_datapath
  import ebus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              cmdSel,
  input  logic [DATA_W-1:0] cmdWData,
  input  logic [DATA_W-1:0] busDIn,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspData,
  output logic              busCsN,
  output logic              busCs2,
  output logic              busSel,
  output logic              busRnw,
  output logic              busE,
  output logic [DATA_W-1:0] busDOut,
  output logic              busDOe
);

  logic              selReg;
  logic [DATA_W-1:0] wdReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg  <= 1'b0;
      wdReg   <= '0;
      rspData <= '0;
      rspDone <= 1'b0;
    end else begin
      if (strobe.load) begin
        selReg <= cmdSel;
        wdReg  <= cmdWData;
      end
      if (strobe.capture) rspData <= busDIn;
      rspDone <= strobe.capture;
    end
  end

  assign busCsN  = !strobe.csOn;
  assign busCs2  = strobe.csOn;
  assign busSel  = selReg;
  assign busRnw  = strobe.csOn ? strobe.rnw : 1'b1;
  assign busE    = strobe.eOn;
  assign busDOut = wdReg;
  assign busDOe  = strobe.oeOn;

  // R3: select and direction steady while the chip is selected
  a_r3_sel_stable: assert property (@(posedge clk) disable iff (!rstN)
    strobe.csOn && $past(strobe.csOn) |-> $stable(selReg) && $stable(strobe.rnw));
  // R7: never drive the bus during a read
  a_r7_no_drive_on_read: assert property (@(posedge clk) disable iff (!rstN)
    strobe.oeOn |-> !strobe.rnw);
  // R6: done comes in the first cycle after E falls
  a_r6_done_after_fall: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |-> !strobe.eOn && $past(strobe.eOn));

endmodule

// File: rtl/ebus_master.sv
module ebus_master
  import ebus_pkg::*;
#(
  parameter int     CLK_NS  = 10,
  parameter int     DATA_W  = 8,
  parameter busNs_t FAST_NS = '{cycNs: 300, rdHighNs: 120, wrHighNs: 60, lowNs: 60,
                                setupNs: 40, holdNs: 15, accNs: 140, disNs: 100},
  parameter busNs_t SLOW_NS = '{cycNs: 1000, rdHighNs: 240, wrHighNs: 120, lowNs: 120,
                                setupNs: 80, holdNs: 30, accNs: 280, disNs: 200}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowMode,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic              cmdRead,
  input  logic              cmdSel,
  input  logic [DATA_W-1:0] cmdWData,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspData,
  output logic              busCsN,
  output logic              busCs2,
  output logic              busSel,
  output logic              busRnw,
  output logic              busE,
  output logic [DATA_W-1:0] busDOut,
  output logic              busDOe,
  input  logic [DATA_W-1:0] busDIn
);

  localparam busTk_t FAST_TK = toTicks(FAST_NS, CLK_NS);
  localparam busTk_t SLOW_TK = toTicks(SLOW_NS, CLK_NS);

  ctrlStrobe_t strobe;

  ebus_ctrl #(.FAST_TK(FAST_TK), .SLOW_TK(SLOW_TK)) u_ctrl (
    .clk(clk), .rstN(rstN), .slowMode(slowMode), .cmdValid(cmdValid),
    .cmdRead(cmdRead), .cmdReady(cmdReady), .strobe(strobe)
  );

  ebus_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdSel(cmdSel), .cmdWData(cmdWData),
    .busDIn(busDIn), .rspDone(rspDone), .rspData(rspData), .busCsN(busCsN),
    .busCs2(busCs2), .busSel(busSel), .busRnw(busRnw), .busE(busE),
    .busDOut(busDOut), .busDOe(busDOe)
  );

endmodule

// File: tb/test_ebus_master.sv
module test_ebus_master;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic slowMode = 1'b0, cmdValid = 1'b0, cmdRead = 1'b0, cmdSel = 1'b0;
  logic [7:0] cmdWData = '0;
  logic cmdReady, rspDone, busCsN, busCs2, busSel, busRnw, busE, busDOe;
  logic [7:0] rspData, busDOut;
  logic [7:0] busDIn = 8'h00;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  ebus_master i_ebus_master (
    .clk(clk), .rstN(rstN), .slowMode(slowMode), .cmdValid(cmdValid),
    .cmdReady(cmdReady), .cmdRead(cmdRead), .cmdSel(cmdSel), .cmdWData(cmdWData),
    .rspDone(rspDone), .rspData(rspData), .busCsN(busCsN), .busCs2(busCs2),
    .busSel(busSel), .busRnw(busRnw), .busE(busE), .busDOut(busDOut),
    .busDOe(busDOe), .busDIn(busDIn)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // expected tick counts for the profile the current transfer should use
  bit expSlow = 1'b0;
  function automatic int eLow(bit s);    return s ? 13 : 7;   endfunction
  function automatic int eHighRd(bit s); return s ? 30 : 16;  endfunction
  function automatic int eHighWr(bit s); return s ? 13 : 7;   endfunction
  function automatic int eHold(bit s);   return s ? 4 : 3;    endfunction
  function automatic int eSetup(bit s);  return s ? 9 : 5;    endfunction
  function automatic int eDis(bit s);    return s ? 21 : 11;  endfunction
  function automatic int eCyc(bit s);    return s ? 101 : 31; endfunction
  function automatic int eAcc(bit s);    return s ? 28 : 14;  endfunction

  // peripheral model and bus monitor, sampled on the falling edge
  logic [7:0] mem [2];
  bit   prevE = 0, prevReady = 1, seenRise = 0, inHold = 0, lastRnw = 1;
  bit   lastSlow = 0;
  int   highCnt = 0, lowCnt = 0, gapCnt = 0, oeRun = 0, holdCnt = 0, driveCnt = 0;
  logic prevSel = 0, prevRnw = 1, prevCsN = 1;

  always @(negedge clk) begin
    if (rstN) begin
      gapCnt++;
      if (busE && !busCsN) begin
        if (highCnt >= eAcc(expSlow)) busDIn <= mem[busSel];
        else busDIn <= 8'hEE;
      end else if (driveCnt == 0) busDIn <= 8'h11;
      // R3: select and direction constant while chip selected
      if (!busCsN && !prevCsN && (busSel !== prevSel || busRnw !== prevRnw))
        check(0, "R3 sel/rnw changed", int'(busSel), int'(prevSel));
      if (busE && busCsN) check(0, "R3 E without CS", 1, 0);
      if (!busCsN && busCs2 !== 1'b1) check(0, "R3 cs2 low while selected", 0, 1);
      // R8: no drive while the peripheral may still drive
      if (driveCnt > 0) begin
        if (busDOe) check(0, "R8 drive inside release window", driveCnt, 0);
        driveCnt--;
      end
      if (busDOe && busRnw) check(0, "R7 drive during read", 1, 0);
      if (busDOe) oeRun++; else oeRun = 0;

      if (busE && !prevE) begin
        check(lowCnt >= eLow(expSlow), "R4 E-low before rise", lowCnt, eLow(expSlow));
        if (seenRise)
          check(gapCnt >= eCyc(lastSlow), "R9 rise to rise", gapCnt, eCyc(lastSlow));
        seenRise = 1; lastSlow = expSlow; gapCnt = 0; highCnt = 0;
        lastRnw = busRnw;
      end
      if (busE) highCnt++;
      if (!busE && prevE) begin
        if (lastRnw) begin
          check(highCnt == eHighRd(expSlow), "R6 read E-high", highCnt, eHighRd(expSlow));
          driveCnt = eDis(expSlow) - 1;
        end else begin
          check(highCnt == eHighWr(expSlow), "R5 write E-high", highCnt, eHighWr(expSlow));
          check(oeRun - 1 >= eSetup(expSlow), "R7 write setup", oeRun - 1, eSetup(expSlow));
          mem[busSel] = busDOut;
          inHold = 1; holdCnt = 0;
        end
      end
      if (inHold) begin
        if (busDOe) holdCnt++;
        else begin
          check(holdCnt == eHold(expSlow), "R7 write hold", holdCnt, eHold(expSlow));
          inHold = 0;
        end
      end
      if (rspDone) check(prevE && !busE, "R6 done timing", int'(busE), 0);
      if (!busE && !busCsN) lowCnt++; else lowCnt = 0;
      if (cmdReady && !prevReady && seenRise)
        check(gapCnt >= eCyc(lastSlow), "R2 ready return", gapCnt, eCyc(lastSlow));
      prevE = busE; prevReady = cmdReady;
      prevSel = busSel; prevRnw = busRnw; prevCsN = busCsN;
    end
  end

  task automatic issue(input bit rd, input bit sel, input logic [7:0] wd, input bit slow);
    @(negedge clk);
    while (!cmdReady) @(negedge clk);
    expSlow = slow; slowMode = slow;
    cmdValid = 1; cmdRead = rd; cmdSel = sel; cmdWData = wd;
    @(negedge clk);
    cmdValid = 0;
    check(!cmdReady, "R2 ready low after accept", int'(cmdReady), 0);
    check(!busCsN && busRnw == rd, "R3 cs and rnw at start", int'(busRnw), int'(rd));
  endtask

  task automatic doWrite(input bit sel, input logic [7:0] wd, input bit slow);
    issue(0, sel, wd, slow);
    while (!cmdReady) @(negedge clk);
    check(mem[sel] == wd, "R7 peripheral got write byte", int'(mem[sel]), int'(wd));
  endtask

  task automatic doRead(input bit sel, input bit slow, input bit flipMode);
    logic [7:0] want;
    want = mem[sel];
    issue(1, sel, 8'h00, slow);
    if (flipMode) slowMode = !slow;  // R10: change mid-transfer
    while (!rspDone) @(negedge clk);
    check(rspData == want, "R6 read data", int'(rspData), int'(want));
    @(negedge clk);
    check(!rspDone, "R6 done one cycle", int'(rspDone), 0);
    while (!cmdReady) @(negedge clk);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check(cmdReady && busCsN && !busCs2 && !busE && !busDOe && !rspDone,
          "R1 reset state", int'({cmdReady, busCsN, busCs2, busE, busDOe, rspDone}), 6'b110000);
    rstN = 1;
    @(negedge clk);
    check(cmdReady && busCsN && !busE, "R1 idle after reset", int'(cmdReady), 1);
  endtask

  initial begin
    mem[0] = 8'h00; mem[1] = 8'h00;
    fork
      begin
        testReset();
        doWrite(0, 8'hA5, 0);
        doWrite(1, 8'h3C, 0);
        doRead(0, 0, 0);
        doRead(1, 1, 0);
        doWrite(0, 8'h96, 1);
        doRead(0, 1, 0);
        doRead(1, 0, 1);   // R10: fast transfer, mode raised after accept
        doRead(0, 1, 1);   // R10: slow transfer, mode dropped after accept
        slowMode = 0;
        doRead(1, 0, 0);   // R8: read then write back to back
        doWrite(1, 8'h5E, 0);
        doRead(1, 0, 0);
      end
      begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule